// File: doc/BRIEF.md
# Floating-Point Coprocessor Control and Condition-Branch Unit

This unit is the control half of a floating-point coprocessor that sits beside a simple integer pipeline. It owns the floating-point control/status word (index 31 in the coprocessor's control-register space). That word holds the rounding-mode field and the FP condition flag. On every issued instruction the unit checks whether the coprocessor is enabled and whether a user-mode extended instruction is allowed. It then resolves the instruction's control effect: a condition branch with its target and delay-slot handling, a control-register read or write, or an integer conditional move keyed on the FP flag.

The pipeline presents one decoded instruction per cycle with `issue_i`. Every instruction class selected by `op_i` is registered, and its result appears one cycle later while `resp_vld_o` is high. A separate compare strobe from the FP comparison datapath updates the condition flag directly. The rounding-mode field and the condition flag are always visible on `rmode_o` and `cond_o`, so the arithmetic units see them before each operation.

The controller has two states. ST_IDLE means no response is pending. ST_RESP means the registered response outputs are valid. The transition taken on a cycle where `issue_i` is high is "accept", which goes from either state to ST_RESP. The transition taken on a cycle where `issue_i` is low is "drain", which goes from either state to ST_IDLE.

Top module: `fpctl_unit`

## Requirements
- R1: After reset the control/status word is zero, so `rmode_o` is 0 (round to nearest), `cond_o` is 0, and `resp_vld_o` is low until the first issue.
- R2: When `sr_cu1_i` is 0, every issued operation raises an exception with `exc_code_o` = 11 and `cause_ce_o` = 1, and it changes no FP state.
- R3: `rmode_o` always equals bits [1:0] of the control/status word. The encodings are 0 for nearest, 1 for toward zero, 2 for toward plus infinity and 3 for toward minus infinity.
- R4: A branch (`op_i` = 1) is taken when the condition flag equals `ft_i[0]`.
- R5: For a branch, `br_target_o` = `npc_i` + sign-extend-18({`imm_i`, 2'b00}).
- R6: A branch that is not taken and has `ft_i[1]` = 1 (likely) asserts `skip_slot_o` with `npc_next_o` = `npc_i` + 4. A non-likely branch that is not taken asserts neither `br_taken_o` nor `skip_slot_o`, and `npc_next_o` = `npc_i`.
- R7: A control read (`op_i` = 2) writes back the full control/status word when `fs_i` = 31, and 0x300 for any other index, with `gpr_we_o` = 1.
- R8: A control write (`op_i` = 3) with `fs_i` = 31 stores `gpr_rs_i` into the control/status word. A write to any other index leaves the word unchanged.
- R9: A conditional move (`op_i` = 4) asserts `gpr_we_o` with data `gpr_rs_i` only when the condition flag equals `tf_i`.
- R10: In user mode (`sr_user_i` = 1) with `sr_xen_i` = 0, the extended operations raise `exc_code_o` = 10 (reserved instruction). These are the FP conditional move (`op_i` = 5) and multiply-add (`op_i` = 6). The plain FP operation (`op_i` = 0) never does.
- R11: A compare strobe writes `cmp_res_i` into the condition flag (bit 23) at the same edge, so the next cycle's branch sees it. It takes priority over a simultaneous control write to that bit.
- R12: An instruction that raises an exception asserts none of `br_taken_o`, `skip_slot_o` or `gpr_we_o`.
- R13: Every issued instruction produces exactly one cycle of `resp_vld_o`, in the cycle after it is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Instruction valid this cycle |
| op_i | input | 3 | Operation class (0 FP op, 1 branch, 2 ctrl read, 3 ctrl write, 4 int cond move, 5 FP cond move, 6 multiply-add) |
| ft_i | input | 5 | ft field; bit 0 branch sense, bit 1 likely |
| fs_i | input | 5 | Control-register index |
| tf_i | input | 1 | Conditional-move sense |
| imm_i | input | 16 | Branch offset in words |
| npc_i | input | 32 | Next-PC of the branch |
| gpr_rs_i | input | 32 | GPR read data |
| sr_cu1_i | input | 1 | Coprocessor usable |
| sr_user_i | input | 1 | User mode |
| sr_xen_i | input | 1 | Extended-instruction enable |
| cmp_vld_i | input | 1 | Compare-result strobe |
| cmp_res_i | input | 1 | Compare result |
| resp_vld_o | output | 1 | Response valid |
| br_taken_o | output | 1 | Branch taken |
| br_target_o | output | 32 | Branch target |
| skip_slot_o | output | 1 | Annul delay slot |
| npc_next_o | output | 32 | Next-PC after branch resolution |
| gpr_we_o | output | 1 | GPR write enable |
| gpr_wdata_o | output | 32 | GPR write data |
| exc_o | output | 1 | Exception pulse |
| exc_code_o | output | 5 | Exception cause code |
| cause_ce_o | output | 2 | Coprocessor-error field |
| rmode_o | output | 2 | Rounding mode |
| cond_o | output | 1 | FP condition flag |

## Verification
All instruction results are registered. An instruction driven at a falling edge is sampled at the next rising edge, and its branch, write-back and exception outputs are read at the falling edge that follows. The control/status word also updates at that rising edge, whether from a control write or a compare strobe. `rmode_o` and `cond_o` are therefore checked at that same falling edge, and a branch issued next already sees the new flag. Every stimulus task starts and ends on a falling edge, so each check lands exactly one cycle after its stimulus and never on a clock edge.

// File: rtl/fpctl_pkg.sv
package fpctl_pkg;
    typedef enum logic [2:0] {
        OP_ARITH  = 3'd0,
        OP_BRANCH = 3'd1,
        OP_RDCR   = 3'd2,
        OP_WRCR   = 3'd3,
        OP_CMOV   = 3'd4,
        OP_FPMOVC = 3'd5,
        OP_MADD   = 3'd6,
        OP_RSVD   = 3'd7
    } fp_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } fsm_e;

    typedef struct packed {
        logic       raise;
        logic [4:0] code;
        logic [1:0] ce;
    } exc_t;
endpackage

// File: rtl/fpctl_gate.sv
module fpctl_gate
    import fpctl_pkg::*;
#(
    parameter logic [4:0] CODE_UNUSABLE = 5'd11,
    parameter logic [4:0] CODE_RESERVED = 5'd10
) (
    input  fp_op_e op,
    input  logic   cu1,
    input  logic   user,
    input  logic   xen,
    output exc_t   exc
);
    logic is_ext;

    always_comb begin
        is_ext = (op == OP_FPMOVC) || (op == OP_MADD);
        exc    = '0;
        if (!cu1) begin
            exc.raise = 1'b1;
            exc.code  = CODE_UNUSABLE;
            exc.ce    = 2'd1;
        end else if (is_ext && user && !xen) begin
            exc.raise = 1'b1;
            exc.code  = CODE_RESERVED;
        end
    end
endmodule

// File: rtl/fpctl_branch.sv
module fpctl_branch #(
    parameter int XLEN = 32
) (
    input  logic            cond,
    input  logic [1:0]      ft_lo,
    input  logic [15:0]     imm,
    input  logic [XLEN-1:0] npc,
    output logic            taken,
    output logic            skip,
    output logic [XLEN-1:0] target,
    output logic [XLEN-1:0] npc_next
);
    localparam int OFS_W = 18;
    logic [XLEN-1:0] ofs;

    always_comb begin
        ofs      = {{(XLEN-OFS_W){imm[15]}}, imm, 2'b00};
        target   = npc + ofs;
        taken    = (cond == ft_lo[0]);
        skip     = !taken && ft_lo[1];
        npc_next = skip ? npc + XLEN'(4) : npc;
    end
endmodule

// File: rtl/fpctl_csr.sv
module fpctl_csr #(
    parameter int XLEN     = 32,
    parameter int COND_BIT = 23
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    input  logic            cmp_vld,
    input  logic            cmp_res,
    output logic [XLEN-1:0] csr_q
);
    logic [XLEN-1:0] csr_d;

    always_comb begin
        csr_d = csr_q;
        if (wr_en)
            csr_d = wr_data;
        if (cmp_vld)
            csr_d[COND_BIT] = cmp_res;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            csr_q <= '0;
        else
            csr_q <= csr_d;
    end
endmodule

// File: rtl/fpctl_unit.sv
module fpctl_unit
    import fpctl_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter int          COND_BIT = 23,
    parameter int          CSR_IDX  = 31,
    parameter logic [31:0] IMPL_ID  = 32'h0000_0300
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_i,
    input  logic [2:0]      op_i,
    input  logic [4:0]      ft_i,
    input  logic [4:0]      fs_i,
    input  logic            tf_i,
    input  logic [15:0]     imm_i,
    input  logic [XLEN-1:0] npc_i,
    input  logic [XLEN-1:0] gpr_rs_i,
    input  logic            sr_cu1_i,
    input  logic            sr_user_i,
    input  logic            sr_xen_i,
    input  logic            cmp_vld_i,
    input  logic            cmp_res_i,
    output logic            resp_vld_o,
    output logic            br_taken_o,
    output logic [XLEN-1:0] br_target_o,
    output logic            skip_slot_o,
    output logic [XLEN-1:0] npc_next_o,
    output logic            gpr_we_o,
    output logic [XLEN-1:0] gpr_wdata_o,
    output logic            exc_o,
    output logic [4:0]      exc_code_o,
    output logic [1:0]      cause_ce_o,
    output logic [1:0]      rmode_o,
    output logic            cond_o
);
    fp_op_e          op;
    exc_t            exc;
    fsm_e            state_q, state_d;
    logic [XLEN-1:0] csr_q;
    logic            cond;
    logic            b_taken, b_skip;
    logic [XLEN-1:0] b_target, b_npc;
    logic            csr_wr;
    logic            r_taken, r_skip, r_we;
    logic [XLEN-1:0] r_target, r_npc, r_wdata;

    assign op   = fp_op_e'(op_i);
    assign cond = csr_q[COND_BIT];

    fpctl_gate u_gate (
        .op   (op),
        .cu1  (sr_cu1_i),
        .user (sr_user_i),
        .xen  (sr_xen_i),
        .exc  (exc)
    );

    fpctl_branch #(.XLEN(XLEN)) u_branch (
        .cond     (cond),
        .ft_lo    (ft_i[1:0]),
        .imm      (imm_i),
        .npc      (npc_i),
        .taken    (b_taken),
        .skip     (b_skip),
        .target   (b_target),
        .npc_next (b_npc)
    );

    assign csr_wr = issue_i && !exc.raise && (op == OP_WRCR) && (fs_i == 5'(CSR_IDX));

    fpctl_csr #(.XLEN(XLEN), .COND_BIT(COND_BIT)) u_csr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (csr_wr),
        .wr_data (gpr_rs_i),
        .cmp_vld (cmp_vld_i),
        .cmp_res (cmp_res_i),
        .csr_q   (csr_q)
    );

    // Result of the instruction presented this cycle
    always_comb begin
        r_taken  = 1'b0;
        r_skip   = 1'b0;
        r_we     = 1'b0;
        r_target = '0;
        r_npc    = '0;
        r_wdata  = '0;
        if (!exc.raise) begin
            unique case (op)
                OP_BRANCH: begin
                    r_taken  = b_taken;
                    r_skip   = b_skip;
                    r_target = b_target;
                    r_npc    = b_npc;
                end
                OP_RDCR: begin
                    r_we    = 1'b1;
                    r_wdata = (fs_i == 5'(CSR_IDX)) ? csr_q : XLEN'(IMPL_ID);
                end
                OP_CMOV: begin
                    r_we    = (cond == tf_i);
                    r_wdata = gpr_rs_i;
                end
                default: ;
            endcase
        end
    end

    // Transitions: accept (issue) and drain (no issue)
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = issue_i ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = issue_i ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !issue_i) begin
            br_taken_o  <= 1'b0;
            br_target_o <= '0;
            skip_slot_o <= 1'b0;
            npc_next_o  <= '0;
            gpr_we_o    <= 1'b0;
            gpr_wdata_o <= '0;
            exc_o       <= 1'b0;
            exc_code_o  <= '0;
            cause_ce_o  <= '0;
        end else begin
            br_taken_o  <= r_taken;
            br_target_o <= r_target;
            skip_slot_o <= r_skip;
            npc_next_o  <= r_npc;
            gpr_we_o    <= r_we;
            gpr_wdata_o <= r_wdata;
            exc_o       <= exc.raise;
            exc_code_o  <= exc.code;
            cause_ce_o  <= exc.ce;
        end
    end

    assign resp_vld_o = (state_q == ST_RESP);
    assign rmode_o    = csr_q[1:0];
    assign cond_o     = cond;
endmodule

// File: rtl/fpctl_chk.sv
module fpctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       issue_i,
    input logic       sr_cu1_i,
    input logic       cmp_vld_i,
    input logic       cmp_res_i,
    input logic       resp_vld_o,
    input logic       br_taken_o,
    input logic       skip_slot_o,
    input logic       gpr_we_o,
    input logic       exc_o,
    input logic [4:0] exc_code_o,
    input logic [1:0] cause_ce_o,
    input logic [1:0] rmode_o,
    input logic       cond_o
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!resp_vld_o && rmode_o == 2'd0 && !cond_o));

    assert_unusable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(issue_i && !sr_cu1_i) |-> (exc_o && exc_code_o == 5'd11 && cause_ce_o == 2'd1));

    assert_likely_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        skip_slot_o |-> !br_taken_o);

    assert_cmp_updates_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmp_vld_i) |-> (cond_o == $past(cmp_res_i)));

    assert_exc_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        exc_o |-> (!br_taken_o && !skip_slot_o && !gpr_we_o));

    assert_resp_follows_R13: assert property (@(posedge clk) disable iff (!rst_n)
        resp_vld_o == $past(issue_i));
endmodule

bind fpctl_unit fpctl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_i     (issue_i),
    .sr_cu1_i    (sr_cu1_i),
    .cmp_vld_i   (cmp_vld_i),
    .cmp_res_i   (cmp_res_i),
    .resp_vld_o  (resp_vld_o),
    .br_taken_o  (br_taken_o),
    .skip_slot_o (skip_slot_o),
    .gpr_we_o    (gpr_we_o),
    .exc_o       (exc_o),
    .exc_code_o  (exc_code_o),
    .cause_ce_o  (cause_ce_o),
    .rmode_o     (rmode_o),
    .cond_o      (cond_o)
);

// File: tb/fpctl_unit_tb.sv
`timescale 1ns/1ps
module fpctl_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic [4:0]  ft_i = '0, fs_i = '0;
    logic        tf_i = 1'b0;
    logic [15:0] imm_i = '0;
    logic [31:0] npc_i = '0, gpr_rs_i = '0;
    logic        sr_cu1_i = 1'b1, sr_user_i = 1'b0, sr_xen_i = 1'b0;
    logic        cmp_vld_i = 1'b0, cmp_res_i = 1'b0;
    logic        resp_vld_o, br_taken_o, skip_slot_o, gpr_we_o, exc_o, cond_o;
    logic [31:0] br_target_o, npc_next_o, gpr_wdata_o;
    logic [4:0]  exc_code_o;
    logic [1:0]  cause_ce_o, rmode_o;

    int n_chk = 0, n_fail = 0;
    logic [31:0] m_csr = '0;

    always #2.5 clk = ~clk;

    fpctl_unit dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_issue(input logic [2:0] op, input logic [4:0] ft, input logic [4:0] fs,
                            input logic tf, input logic [15:0] imm, input logic [31:0] npc,
                            input logic [31:0] rs);
        op_i = op; ft_i = ft; fs_i = fs; tf_i = tf; imm_i = imm; npc_i = npc; gpr_rs_i = rs;
        issue_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        issue_i = 1'b0;
    endtask

    task automatic do_cmp(input logic r);
        cmp_vld_i = 1'b1; cmp_res_i = r;
        @(posedge clk);
        @(negedge clk);
        cmp_vld_i = 1'b0;
        m_csr[23] = r;
    endtask

    initial begin
        #(5.0 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 resp_vld", {31'd0, resp_vld_o}, 0);
        chk("R1 rmode", {30'd0, rmode_o}, 0);
        chk("R1 cond", {31'd0, cond_o}, 0);
        do_issue(3'd2, 0, 5'd31, 0, 0, 0, 0);
        chk("R1 csr read", gpr_wdata_o, 0);
        chk("R13 resp after issue", {31'd0, resp_vld_o}, 1);
        @(negedge clk);
        chk("R13 resp single", {31'd0, resp_vld_o}, 0);

        // R3/R8 write every rounding mode and read back
        for (int rm = 0; rm < 4; rm++) begin
            logic [31:0] v;
            v = 32'hA500_1230 | 32'(rm) | ((rm % 2) ? 32'h0080_0000 : 32'h0);
            do_issue(3'd3, 0, 5'd31, 0, 0, 0, v);
            m_csr = v;
            chk("R3 rmode", {30'd0, rmode_o}, 32'(rm));
            chk("R8 cond from write", {31'd0, cond_o}, {31'd0, v[23]});
            do_issue(3'd2, 0, 5'd31, 0, 0, 0, 0);
            chk("R8 readback", gpr_wdata_o, v);
        end

        // R7 all control-register indices
        for (int i = 0; i < 32; i++) begin
            do_issue(3'd2, 0, 5'(i), 0, 0, 0, 32'hDEAD_BEEF);
            chk("R7 read data", gpr_wdata_o, (i == 31) ? m_csr : 32'h300);
            chk("R7 read we", {31'd0, gpr_we_o}, 1);
        end

        // R8 write to another index ignored
        do_issue(3'd3, 0, 5'd7, 0, 0, 0, 32'h0000_0002);
        do_issue(3'd2, 0, 5'd31, 0, 0, 0, 0);
        chk("R8 other index ignored", gpr_wdata_o, m_csr);

        // R4/R5/R6 branch sweep
        for (int c = 0; c < 2; c++) begin
            do_cmp(c[0]);
            chk("R11 cond after compare", {31'd0, cond_o}, 32'(c));
            for (int ft = 0; ft < 4; ft++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [15:0] imm;
                    logic [31:0] npc, tgt;
                    logic tk, sk;
                    imm = (k == 0) ? 16'h0000 : (k == 1) ? 16'h0004 : (k == 2) ? 16'h7FFF : 16'h8000;
                    npc = 32'h1000_0040 + 32'(k * 256);
                    tgt = npc + {{14{imm[15]}}, imm, 2'b00};
                    tk  = (c == (ft % 2));
                    sk  = !tk && (ft >= 2);
                    do_issue(3'd1, 5'(ft), 0, 0, imm, npc, 0);
                    chk("R4 taken", {31'd0, br_taken_o}, {31'd0, tk});
                    chk("R5 target", br_target_o, tgt);
                    chk("R6 skip", {31'd0, skip_slot_o}, {31'd0, sk});
                    chk("R6 npc_next", npc_next_o, sk ? npc + 4 : npc);
                end
            end
        end

        // R11 compare wins over simultaneous write
        cmp_vld_i = 1'b1; cmp_res_i = 1'b1;
        do_issue(3'd3, 0, 5'd31, 0, 0, 0, 32'h0000_0003);
        cmp_vld_i = 1'b0;
        m_csr = 32'h0080_0003;
        chk("R11 priority cond", {31'd0, cond_o}, 1);
        chk("R11 priority rmode", {30'd0, rmode_o}, 3);
        do_issue(3'd1, 5'd1, 0, 0, 16'h0001, 32'h100, 0);
        chk("R11 next branch sees flag", {31'd0, br_taken_o}, 1);

        // R9 conditional move
        for (int c = 0; c < 2; c++) begin
            do_cmp(c[0]);
            for (int t = 0; t < 2; t++) begin
                do_issue(3'd4, 0, 0, t[0], 0, 0, 32'h1234_5678 + 32'(t));
                chk("R9 we", {31'd0, gpr_we_o}, (c == t) ? 1 : 0);
                if (c == t) chk("R9 data", gpr_wdata_o, 32'h1234_5678 + 32'(t));
            end
        end

        // R2/R10/R12 gate sweep
        for (int cu = 0; cu < 2; cu++)
            for (int us = 0; us < 2; us++)
                for (int xe = 0; xe < 2; xe++)
                    for (int o = 0; o < 7; o++) begin
                        logic ex;
                        logic [4:0] code;
                        sr_cu1_i = cu[0]; sr_user_i = us[0]; sr_xen_i = xe[0];
                        ex   = (cu == 0) || ((o == 5 || o == 6) && us == 1 && xe == 0);
                        code = (cu == 0) ? 5'd11 : ex ? 5'd10 : 5'd0;
                        do_issue(3'(o), 5'd1, 5'd31, m_csr[23], 0, 32'h200, 32'h0000_0001);
                        if (!ex && o == 3) m_csr = 32'h0000_0001;
                        chk((cu == 0) ? "R2 exc" : "R10 exc", {31'd0, exc_o}, {31'd0, ex});
                        chk((cu == 0) ? "R2 code" : "R10 code", {27'd0, exc_code_o}, {27'd0, code});
                        chk("R2 ce", {30'd0, cause_ce_o}, (cu == 0) ? 1 : 0);
                        if (ex) chk("R12 quiet", {29'd0, br_taken_o, skip_slot_o, gpr_we_o}, 0);
                        chk("R2 state kept", {30'd0, rmode_o}, {30'd0, m_csr[1:0]});
                    end
        sr_cu1_i = 1'b1; sr_user_i = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule